// File: doc/BRIEF.md
# Configurable TDM/I2S Transmit Serializer

This block drives the transmit side of one serial audio port as bus master. From the system clock it makes a bit clock at half that rate. It also makes a frame sync: a two-level left/right clock for stereo, or a short pulse for multi-slot TDM frames. Alongside these it shifts out a serial data line. Each slot of a frame carries one sample taken from a valid/ready stream. A slot enable mask chooses which slots carry data, so only enabled slots pull a sample.

A static configuration input sets the rest, and it is changed only while transmit is off. It sets the slot container size and how many low container bits hold the sample. It also sets the bit order, which bit-clock edge launches data and sync, and the sync polarity or pulse width. Last, it sets a data offset that moves the sample stream relative to the frame start. An enable and a soft reset stop the port and return it to a quiet state. When a sample is due and the stream has none, the block sends silence and flags it.

Top module: `tdm_tx_serializer`

## Requirements
- R1: While `tx_en` is low or `soft_rst` is high, `s_ready` is low, and from the next cycle `bclk_o`, `fsync_o` and `sdata_o` are low; no sample is taken. On re-enable the port starts again from its first frame.
- R2: While running, `bclk_o` toggles every clock, so one bit period is two clocks starting with the low half. The first bit period after enable is an idle period with sync and data low, and frame position 0 follows it.
- R3: Size code c (1..7) gives a container of 4c+4 bits per slot, and code 0 acts as 8 bits. A frame is slots × container bits long. In LRCK mode (`cfg_fsync_mode`=0) a frame always has 2 slots. In pulse mode it has `cfg_slots_m1`+1 slots.
- R4: In LRCK mode the first half of the frame is slot 0 (left). With `cfg_lrck_pol`=0 the sync is low during the first half and high during the second. With 1 it is high during the first half.
- R5: In pulse mode (`cfg_fsync_mode`=1) the sync is high for the first `cfg_fs_width`+1 bit periods of each frame and low otherwise.
- R6: The sample width is the container minus `cfg_mask` bits. The sample sits in `s_data[width-1:0]`. With `cfg_lsb_first`=0 bit width-1 goes first, and with 1 bit 0 goes first. The remaining container bits are sent as zero.
- R7: With `cfg_neg_edge`=0, data and sync change only on rising `bclk_o` and are stable across falling edges. With 1 they change only on falling `bclk_o`.
- R8: The data of slot 0 of each frame starts `cfg_offset` bit periods after frame position 0, and the offset must be less than the frame length. The tail of the last slot runs into the next frame. Data before the first data start is zero.
- R9: Mask bit i enables slot i. `s_ready` is high for one clock, in the high half of the bit period just before an enabled slot's first bit. A disabled slot sends zeros and consumes no sample.
- R10: If `s_valid` is low when `s_ready` is high, that slot is sent as all zeros and `underflow_o` is high in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| soft_rst | input | 1 | Synchronous soft reset, overrides enable |
| cfg_fsync_mode | input | 1 | 0 = left/right clock framing, 1 = pulse framing |
| cfg_lrck_pol | input | 1 | Left/right clock polarity |
| cfg_size | input | 3 | Container size code |
| cfg_mask | input | 3 | Container bits not carrying sample |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_neg_edge | input | 1 | Launch edge select |
| cfg_slots_m1 | input | 3 | Slots per frame minus one (pulse mode) |
| cfg_slot_en | input | 8 | Per-slot enable mask |
| cfg_fs_width | input | 8 | Sync pulse width minus one, in bit periods |
| cfg_offset | input | 11 | Data offset in bit periods |
| s_valid | input | 1 | Sample available |
| s_data | input | 32 | Sample, right-justified |
| s_ready | output | 1 | Sample taken this clock |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync |
| sdata_o | output | 1 | Serial data |
| underflow_o | output | 1 | Sample missing for an enabled slot |

## Verification
The serializer is run with five framings: stereo left/right with a one-bit offset and falling-edge launch; a four-slot pulse frame with one slot disabled, a masked 8-bit container, LSB-first order and rising-edge launch; reversed polarity with a large offset and only the right channel enabled; an eight-slot frame with a one-bit pulse and an offset that spills into the next frame; and a three-slot frame fed no samples at all. A receiver model in the bench decodes the line on the edge opposite the launch edge and compares every bit period with a frame built from the requirements. Bit-order, masking and edge errors show up as data mismatches. A disabled slot that wrongly takes a sample shifts every later sample, and a wrong offset or width moves sync or data by whole periods. A soft reset mid-frame followed by a fresh run checks the quiet state and the restart.

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer #(
  parameter int DW        = 32,
  parameter int MAX_SLOTS = 8,
  parameter int OFF_W     = 11,
  parameter int FSW_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_en,
  input  logic                 soft_rst,
  input  logic                 cfg_fsync_mode,
  input  logic                 cfg_lrck_pol,
  input  logic [2:0]           cfg_size,
  input  logic [2:0]           cfg_mask,
  input  logic                 cfg_lsb_first,
  input  logic                 cfg_neg_edge,
  input  logic [$clog2(MAX_SLOTS)-1:0] cfg_slots_m1,
  input  logic [MAX_SLOTS-1:0] cfg_slot_en,
  input  logic [FSW_W-1:0]     cfg_fs_width,
  input  logic [OFF_W-1:0]     cfg_offset,
  input  logic                 s_valid,
  input  logic [DW-1:0]        s_data,
  output logic                 s_ready,
  output logic                 bclk_o,
  output logic                 fsync_o,
  output logic                 sdata_o,
  output logic                 underflow_o
);
  localparam int SW = $clog2(MAX_SLOTS);
  localparam int NW = SW + 1;
  localparam int CW = $clog2(DW);
  localparam int BW = CW + 1;
  localparam int PW = OFF_W;

  logic          run, ph, started, drun, tick;
  logic [PW-1:0] pos, pos_n, flen;
  logic [SW-1:0] dslot, ds_n;
  logic [BW-1:0] dbix, db_n, cont, vw;
  logic [NW-1:0] nslot;
  logic [DW-1:0] samp;
  logic [CW-1:0] idx;
  logic          drun_n, slot_start, take, bit_c, sync_c, dly_d, dly_s;

  assign run   = tx_en & ~soft_rst;
  assign tick  = run & ph;
  assign cont  = (cfg_size == 3'd0) ? BW'(8) : BW'({cfg_size, 2'b00}) + BW'(4);
  assign vw    = cont - BW'(cfg_mask);
  assign nslot = cfg_fsync_mode ? NW'(cfg_slots_m1) + NW'(1) : NW'(2);
  assign flen  = PW'(nslot) * PW'(cont);
  assign pos_n = !started ? '0 : ((pos == flen - PW'(1)) ? '0 : pos + PW'(1));

  always_comb begin
    drun_n = drun;
    ds_n   = dslot;
    db_n   = dbix;
    if (!drun) begin
      if (pos_n == cfg_offset) begin
        drun_n = 1'b1;
        ds_n   = '0;
        db_n   = '0;
      end
    end else if (dbix == cont - BW'(1)) begin
      db_n = '0;
      ds_n = (NW'(dslot) == nslot - NW'(1)) ? '0 : dslot + SW'(1);
    end else begin
      db_n = dbix + BW'(1);
    end
  end

  assign slot_start  = drun_n && (db_n == '0);
  assign take        = tick && slot_start && cfg_slot_en[ds_n];
  assign s_ready     = take;
  assign underflow_o = take && !s_valid;

  assign idx    = cfg_lsb_first ? dbix[CW-1:0] : CW'(vw - BW'(1) - dbix);
  assign bit_c  = drun && (dbix < vw) && samp[idx];
  assign sync_c = started && (cfg_fsync_mode ? (pos <= PW'(cfg_fs_width))
                                             : ((pos >= PW'(cont)) ^ cfg_lrck_pol));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 1'b0; started <= 1'b0; pos <= '0; drun <= 1'b0;
      dslot <= '0; dbix <= '0; samp <= '0; dly_d <= 1'b0; dly_s <= 1'b0;
    end else if (!run) begin
      ph <= 1'b0; started <= 1'b0; pos <= '0; drun <= 1'b0;
      dslot <= '0; dbix <= '0; samp <= '0; dly_d <= 1'b0; dly_s <= 1'b0;
    end else begin
      ph <= ~ph;
      if (ph) begin
        started <= 1'b1;
        pos     <= pos_n;
        drun    <= drun_n;
        dslot   <= ds_n;
        dbix    <= db_n;
        if (slot_start) samp <= (take && s_valid) ? s_data : '0;
      end else begin
        dly_d <= bit_c;
        dly_s <= sync_c;
      end
    end
  end

  assign bclk_o  = ph;
  assign sdata_o = cfg_neg_edge ? bit_c  : dly_d;
  assign fsync_o = cfg_neg_edge ? sync_c : dly_s;
endmodule

module tdm_tx_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic soft_rst,
  input logic cfg_neg_edge,
  input logic s_valid,
  input logic s_ready,
  input logic bclk_o,
  input logic fsync_o,
  input logic sdata_o,
  input logic underflow_o
);
  // R1
  off_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en || soft_rst) |-> !s_ready);
  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en || soft_rst) |=> (!bclk_o && !fsync_o && !sdata_o));
  // R2
  bclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !soft_rst) |=> (bclk_o != $past(bclk_o)));
  // R7
  rise_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !soft_rst && $past(tx_en && !soft_rst) && !cfg_neg_edge &&
     $past(!cfg_neg_edge) && !bclk_o) |-> ($stable(sdata_o) && $stable(fsync_o)));
  // R7
  fall_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !soft_rst && $past(tx_en && !soft_rst) && cfg_neg_edge &&
     $past(cfg_neg_edge) && bclk_o) |-> ($stable(sdata_o) && $stable(fsync_o)));
  // R9
  ready_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !bclk_o);
  // R10
  underflow_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> (bclk_o && tx_en && !s_valid));
endmodule

bind tdm_tx_serializer tdm_tx_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .soft_rst(soft_rst),
  .cfg_neg_edge(cfg_neg_edge), .s_valid(s_valid), .s_ready(s_ready),
  .bclk_o(bclk_o), .fsync_o(fsync_o), .sdata_o(sdata_o), .underflow_o(underflow_o)
);

// File: tb/tdm_tx_serializer_tb.sv
module tdm_tx_serializer_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, tx_en = 0, soft_rst = 0;
  logic c_fmode = 0, c_pol = 0, c_lsb = 0, c_neg = 0, vld = 1;
  logic [2:0] c_size = 3, c_mask = 0, c_sm1 = 0;
  logic [7:0] c_en = 8'h03, c_fsw = 0;
  logic [10:0] c_off = 0;
  logic [31:0] s_data;
  logic s_ready, bclk_o, fsync_o, sdata_o, underflow_o;

  logic [31:0] smp [0:127];
  int ptr = 0, nchk = 0, nerr = 0;
  logic cap_d [0:1023];
  logic cap_s [0:1023];
  int ncap = 0, cyc = 0, last_rise = 0, bad_per = 0, uf_cnt = 0, uf_lim = 100000;
  logic mon_on = 0, prev_b = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign s_data = smp[ptr];

  tdm_tx_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .soft_rst(soft_rst),
    .cfg_fsync_mode(c_fmode), .cfg_lrck_pol(c_pol), .cfg_size(c_size),
    .cfg_mask(c_mask), .cfg_lsb_first(c_lsb), .cfg_neg_edge(c_neg),
    .cfg_slots_m1(c_sm1), .cfg_slot_en(c_en), .cfg_fs_width(c_fsw),
    .cfg_offset(c_off), .s_valid(vld), .s_data(s_data), .s_ready(s_ready),
    .bclk_o(bclk_o), .fsync_o(fsync_o), .sdata_o(sdata_o), .underflow_o(underflow_o)
  );

  always @(posedge clk) if (s_ready && vld) ptr <= ptr + 1;

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (bclk_o && !prev_b) begin
        if (last_rise != 0 && cyc - last_rise != 2) bad_per++;
        last_rise = cyc;
      end
      if ((c_neg && bclk_o && !prev_b) || (!c_neg && !bclk_o && prev_b)) begin
        if (ncap < 1024) begin
          cap_d[ncap] = sdata_o;
          cap_s[ncap] = fsync_o;
        end
        ncap++;
      end
      if (underflow_o && ncap < uf_lim) uf_cnt++;
    end
    prev_b = bclk_o;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int cont_bits();
    return (c_size == 0) ? 8 : 4 * int'(c_size) + 4;
  endfunction

  function automatic int nslots();
    return c_fmode ? int'(c_sm1) + 1 : 2;
  endfunction

  function automatic logic exp_sync(int g);
    int c = cont_bits();
    int p = g % (c * nslots());
    if (c_fmode) return logic'(p <= int'(c_fsw));
    return logic'((p >= c) ^ c_pol);
  endfunction

  function automatic logic exp_data(int g);
    int c = cont_bits();
    int w = c - int'(c_mask);
    int ns = nslots();
    int t = g - int'(c_off);
    int sl, fr, ne = 0, below = 0, b, ix, n;
    if (t < 0 || !vld) return 1'b0;
    sl = (t / c) % ns;
    fr = t / (c * ns);
    if (!c_en[sl]) return 1'b0;
    for (int i = 0; i < ns; i++) if (c_en[i]) begin
      ne++;
      if (i < sl) below++;
    end
    n = fr * ne + below;
    b = t % c;
    if (b >= w) return 1'b0;
    ix = c_lsb ? b : w - 1 - b;
    return smp[n][ix];
  endfunction

  task automatic run_case(string name, int n, string rq_d, string rq_s);
    int md = 0, ms = 0, fd = -1, fs = -1;
    @(negedge clk);
    ncap = 0; last_rise = 0; bad_per = 0; uf_cnt = 0; mon_on = 1;
    tx_en = 1;
    wait (ncap >= n + 1);
    @(negedge clk);
    tx_en = 0;
    mon_on = 0;
    repeat (4) @(negedge clk);
    for (int k = 0; k <= n; k++) begin
      logic ed = (k == 0) ? 1'b0 : exp_data(k - 1);
      logic es = (k == 0) ? 1'b0 : exp_sync(k - 1);
      if (cap_d[k] !== ed) begin md++; if (fd < 0) fd = k; end
      if (cap_s[k] !== es) begin ms++; if (fs < 0) fs = k; end
    end
    chk(md == 0, rq_d, {name, " data mismatches (first at capture ", $sformatf("%0d)", fd)}, md, 0);
    chk(ms == 0, rq_s, {name, " sync mismatches (first at capture ", $sformatf("%0d)", fs)}, ms, 0);
    chk(bad_per == 0, "R2", {name, " bit clock period violations"}, bad_per, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(!bclk_o && !fsync_o && !sdata_o, "R1", "outputs low in reset", {bclk_o, fsync_o, sdata_o}, 0);
    rst_n = 1;
    repeat (20) @(negedge clk);
    chk(!s_ready && !bclk_o && !sdata_o && !fsync_o, "R1", "idle while disabled",
        {s_ready, bclk_o, fsync_o, sdata_o}, 0);
    chk(ptr == 0, "R1", "no sample taken while disabled", ptr, 0);
  endtask

  task automatic t_stereo;
    c_fmode = 0; c_pol = 0; c_size = 3; c_mask = 0; c_lsb = 0; c_neg = 1;
    c_off = 1; c_en = 8'h03; vld = 1; ptr = 0;
    run_case("stereo 16b offset 1", 98, "R6 R8 R3", "R4 R3");
    chk(uf_cnt == 0, "R10", "no underflow with samples present", uf_cnt, 0);
    chk(ptr == 7, "R9", "samples taken in stereo run", ptr, 7);
  endtask

  task automatic t_tdm_mask;
    c_fmode = 1; c_sm1 = 3; c_en = 8'b0000_1011; c_size = 1; c_mask = 2;
    c_lsb = 1; c_neg = 0; c_fsw = 2; c_off = 0; vld = 1; ptr = 0;
    run_case("tdm4 slot2 off lsb", 100, "R9 R6 R7", "R5 R7");
  endtask

  task automatic t_right_only;
    c_fmode = 0; c_pol = 1; c_size = 7; c_mask = 4; c_lsb = 0; c_neg = 0;
    c_off = 3; c_en = 8'h02; vld = 1; ptr = 0;
    run_case("stereo pol1 right only", 140, "R9 R6 R8", "R4");
  endtask

  task automatic t_tdm8_spill;
    c_fmode = 1; c_sm1 = 7; c_en = 8'hFF; c_size = 2; c_mask = 0; c_lsb = 0;
    c_neg = 1; c_fsw = 0; c_off = 5; vld = 1; ptr = 0;
    run_case("tdm8 12b offset 5", 200, "R8 R3", "R5 R3");
  endtask

  task automatic t_underflow;
    c_fmode = 1; c_sm1 = 2; c_en = 8'b0000_0101; c_size = 1; c_mask = 0;
    c_lsb = 0; c_neg = 1; c_fsw = 7; c_off = 0; vld = 0; ptr = 0; uf_lim = 52;
    run_case("tdm3 starved", 60, "R10", "R5");
    chk(uf_cnt == 5, "R10", "underflow pulses before capture 52", uf_cnt, 5);
    chk(ptr == 0, "R10", "no transfer while valid low", ptr, 0);
    uf_lim = 100000; vld = 1;
  endtask

  task automatic t_soft_reset;
    int bad = 0;
    c_fmode = 1; c_sm1 = 3; c_en = 8'hFF; c_size = 1; c_mask = 0; c_lsb = 0;
    c_neg = 1; c_fsw = 1; c_off = 0; vld = 1; ptr = 0;
    @(negedge clk);
    tx_en = 1;
    repeat (37) @(negedge clk);
    soft_rst = 1;
    @(negedge clk);
    repeat (8) begin
      @(negedge clk);
      if (bclk_o || fsync_o || sdata_o || s_ready) bad++;
    end
    chk(bad == 0, "R1", "quiet during soft reset", bad, 0);
    tx_en = 0; soft_rst = 0; ptr = 0;
    run_case("restart after soft reset", 80, "R1 R2", "R1 R5");
  endtask

  initial begin
    for (int i = 0; i < 128; i++) smp[i] = (32'h9E3779B9 * (i + 1)) ^ (i << 11);
    t_reset();
    t_stereo();
    t_tdm_mask();
    t_right_only();
    t_tdm8_spill();
    t_underflow();
    t_soft_reset();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++; nerr++;
    $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", ncap, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule